// File: doc/BRIEF.md
# Watchdog Timer with Timed Change Protection

This block is a watchdog timer. It counts pulses of a slow tick, nominally 128 kHz and delivered as single-cycle enables in the system clock domain. While it runs, software must restart the count before it reaches the timeout. The timeout is `2^(BASE_LOG2 + P)` ticks, where P is a 4-bit prescaler select in the control register. With the default `BASE_LOG2` of 11, that is 2048 << P ticks. When the count reaches the timeout, the block pulses an interrupt if the interrupt enable is set. If the reset enable is set, it also pulses a system reset request and latches a reset flag.

The control register is guarded so that runaway code cannot easily disable the watchdog. The reset enable can always be set, but clearing it or changing the prescaler needs an unlock. The unlock is a single write with both the unlock bit and the reset-enable bit at one. It opens a window that lasts a fixed number of system clocks (`CEN_CYCLES`, default 4). The next write inside that window may change the guarded fields, and that write also closes the window. While the reset flag is set, the reset enable stays at one even inside the window. A kick input, which models the software "restart watchdog" operation, restarts the count when the reset enable is set.

Control register layout, used for both writes and read-back: bit 0 is reset enable, bit 1 is interrupt enable, bit 2 is the unlock window, bit 3 is the reset flag, and bits 7:4 are the prescaler select.

Top module: `wdg_guard`

## Requirements
- R1: After a synchronous reset, `ctrl_rd` reads 0x00 and `irq` and `rst_req` are 0.
- R2: While bit 0 or bit 1 is set, the block counts `tick` cycles. After 2^(BASE_LOG2+P) ticks with no restart, `irq` is high for exactly one cycle if bit 1 is set. The pulse appears one clock after the cycle that carries the final tick.
- R3: When the count expires with bit 0 set, `rst_req` is high for one cycle and bit 3 reads 1 from that same cycle.
- R4: Outside the window, a write with bits 2 and 0 both at 1 sets bit 2 and changes no other field. Bit 2 then reads 1 for exactly `CEN_CYCLES` clocks and clears itself.
- R5: Outside the window, a write can set bit 0 but cannot clear it. It ignores bits 7:4 and loads bit 1 from the written value.
- R6: A write while bit 2 reads 1 loads bits 0, 1 and 7:4 from the written value and clears bit 2.
- R7: If bit 3 was 1 before a write, bit 0 stays 1 even inside the window. It also stays 1 when an expiry sets bit 3 in the same cycle.
- R8: Every write loads bit 3 with (old bit 3 AND written bit 3). Writing 0 clears the flag, and writing 1 leaves it unchanged.
- R9: When bits 0 and 1 are both 0, the count stops and clears and no pulse occurs. Any change of the run state (bit 0 OR bit 1), or of bits 7:4, restarts the count from zero.
- R10: `kick` restarts the count from zero when bit 0 is 1. It has no effect when bit 0 is 0.
- R11: A restart in the same cycle as the final tick suppresses that expiry, and the next expiry comes a full timeout later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow-clock count enable, one system cycle wide per tick |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| kick | input | 1 | Watchdog restart request |
| rst_req | output | 1 | One-cycle system reset request on expiry |
| irq | output | 1 | One-cycle interrupt pulse on expiry |
| ctrl_rd | output | 8 | Control register read-back |

## Verification
The assertions assume that `tick` and `kick` are synchronous to `clk`. They also assume that the timeout is longer than a few clocks, so two expiry pulses can never fall on neighbouring cycles. Because the prescaler and `BASE_LOG2` keep every timeout at eight ticks or more, each pulse checker may require that the cycle after a pulse is low. The random stimulus limits the prescaler to values 0 to 2 so that expiries happen often. It biases about a quarter of its writes toward the unlock pattern, so that window writes, pinned reset enables and flag clears all occur. `tick` is driven on about half of the cycles, which exercises counting that skips cycles.

// File: rtl/wdg_guard_pkg.sv
// Package: wdg_guard_pkg
// Shared field layout and widths for the guarded watchdog.
// The packed struct order is the register's bit order as read back.
package wdg_guard_pkg;

    localparam int CTRL_W = 8;
    localparam int PSEL_W = 4;

    // Control register view: [7:4] prescaler, [3] flag, [2] window, [1] irq enable, [0] reset enable
    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic              rfl;
        logic              cen;
        logic              ien;
        logic              ren;
    } wdg_ctrl_t;

endpackage

// File: rtl/wdg_unlock.sv
// Module: wdg_unlock
// Holds the change window open for CEN_CYCLES system clocks after an unlock
// request. A write inside the window closes it at once.
// Assumes: open_i is only asserted while the window is closed; CEN_CYCLES >= 2.
module wdg_unlock #(
    parameter int CEN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic close_i,
    output logic cen_o
);

    localparam int AW = (CEN_CYCLES > 2) ? $clog2(CEN_CYCLES) : 1;
    localparam logic [AW-1:0] LAST = AW'(CEN_CYCLES - 1);
    localparam logic [AW-1:0] ONE  = AW'(1);

    logic          cen_q;
    logic [AW-1:0] age_q;

    // Open the window, then age it until it ends on its own or is used by a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_q <= 1'b0;
            age_q <= '0;
        end else if (open_i && !cen_q) begin
            cen_q <= 1'b1;
            age_q <= '0;
        end else if (cen_q) begin
            if (close_i || (age_q == LAST)) begin
                cen_q <= 1'b0;
            end else begin
                age_q <= age_q + ONE;
            end
        end
    end

    assign cen_o = cen_q;

endmodule

// File: rtl/wdg_ctrl_reg.sv
// Module: wdg_ctrl_reg
// Control register with write protection. Outside the window, reset enable
// can only be set and the prescaler is frozen. Inside the window the
// guarded fields load freely, except that a set reset flag pins reset enable.
// Also reports whether a write changes the run state or the prescaler.
// Assumes: flag_set_i is an expiry seen while reset enable is one.
module wdg_ctrl_reg
    import wdg_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              cen_i,
    input  logic              flag_set_i,
    output logic              ren_o,
    output logic              ien_o,
    output logic              rfl_o,
    output logic [PSEL_W-1:0] psel_o,
    output logic              open_o,
    output logic              close_o,
    output logic              cfg_restart_o
);

    wdg_ctrl_t         wd;
    logic              ren_q, ien_q, rfl_q;
    logic [PSEL_W-1:0] psel_q;
    logic              ren_w, ien_n, rfl_n;
    logic [PSEL_W-1:0] psel_n;

    assign wd = wdg_ctrl_t'(wr_data);

    // Unlock request and window use, both derived from the incoming write
    assign open_o  = wr_en && !cen_i && wd.cen && wd.ren;
    assign close_o = wr_en && cen_i;

    // Next field values from a write, before any pinning from an expiry
    always_comb begin
        ren_w  = ren_q;
        ien_n  = ien_q;
        psel_n = psel_q;
        rfl_n  = rfl_q;
        if (wr_en) begin
            rfl_n = rfl_q & wd.rfl;
            if (cen_i) begin
                ren_w  = rfl_q | wd.ren;
                ien_n  = wd.ien;
                psel_n = wd.psel;
            end else if (!(wd.cen && wd.ren)) begin
                ren_w = ren_q | wd.ren;
                ien_n = wd.ien;
            end
        end
    end

    // Restart when the write flips the run state or moves the prescaler
    assign cfg_restart_o = ((ren_w | ien_n) != (ren_q | ien_q)) || (psel_n != psel_q);

    // Register update; an expiry with reset enable latches the flag and holds reset enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ren_q  <= 1'b0;
            ien_q  <= 1'b0;
            rfl_q  <= 1'b0;
            psel_q <= '0;
        end else begin
            ren_q  <= ren_w | flag_set_i;
            ien_q  <= ien_n;
            rfl_q  <= rfl_n | flag_set_i;
            psel_q <= psel_n;
        end
    end

    assign ren_o  = ren_q;
    assign ien_o  = ien_q;
    assign rfl_o  = rfl_q;
    assign psel_o = psel_q;

endmodule

// File: rtl/wdg_counter.sv
// Module: wdg_counter
// Counts slow ticks while running and flags expiry on the tick that
// completes 2^(BASE_LOG2+psel) ticks. The terminal value comes from one
// right shift of an all-ones constant, so no comparator per prescaler value.
// Assumes: restart_i has priority over expiry in the same cycle.
module wdg_counter
    import wdg_guard_pkg::*;
#(
    parameter int BASE_LOG2 = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic              tick_i,
    input  logic [PSEL_W-1:0] psel_i,
    output logic              expire_o
);

    localparam int MAXP  = (1 << PSEL_W) - 1;
    localparam int CNT_W = BASE_LOG2 + MAXP;
    localparam logic [CNT_W-1:0]  ALL1 = '1;
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);
    localparam logic [PSEL_W-1:0] PMAX = PSEL_W'(MAXP);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_v;
    logic [PSEL_W-1:0] shamt;

    // Terminal count for the selected prescaler
    assign shamt  = PMAX - psel_i;
    assign last_v = ALL1 >> shamt;

    // Expiry: running, a tick arrives, count at its terminal value, no restart pending
    assign expire_o = run_i && tick_i && (cnt_q == last_v) && !restart_i;

    // Tick counter: cleared when stopped, restarted or expired
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !run_i || expire_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/wdg_guard.sv
// Module: wdg_guard
// Guarded watchdog top level. It joins the protected control register,
// the unlock window and the tick counter, and registers the one-cycle
// reset request and interrupt pulses.
// Assumes: tick is a single-cycle enable synchronous to clk.
module wdg_guard
    import wdg_guard_pkg::*;
#(
    parameter int BASE_LOG2  = 11,
    parameter int CEN_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              kick,
    output logic              rst_req,
    output logic              irq,
    output logic [CTRL_W-1:0] ctrl_rd
);

    logic              ren, ien, rfl, cen;
    logic [PSEL_W-1:0] psel;
    logic              open_req, close_req, cfg_restart;
    logic              restart, expire;
    logic              irq_q, rst_q;
    wdg_ctrl_t         rd_view;

    wdg_ctrl_reg u_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .cen_i         (cen),
        .flag_set_i    (expire && ren),
        .ren_o         (ren),
        .ien_o         (ien),
        .rfl_o         (rfl),
        .psel_o        (psel),
        .open_o        (open_req),
        .close_o       (close_req),
        .cfg_restart_o (cfg_restart)
    );

    wdg_unlock #(.CEN_CYCLES(CEN_CYCLES)) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_i  (open_req),
        .close_i (close_req),
        .cen_o   (cen)
    );

    // A kick counts only while reset enable is set
    assign restart = cfg_restart || (kick && ren);

    wdg_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ren || ien),
        .restart_i (restart),
        .tick_i    (tick),
        .psel_i    (psel),
        .expire_o  (expire)
    );

    // Output pulses, qualified by the enables in force at expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            irq_q <= expire && ien;
            rst_q <= expire && ren;
        end
    end

    // Read-back assembled in register bit order
    always_comb begin
        rd_view.psel = psel;
        rd_view.rfl  = rfl;
        rd_view.cen  = cen;
        rd_view.ien  = ien;
        rd_view.ren  = ren;
    end

    assign ctrl_rd = rd_view;
    assign irq     = irq_q;
    assign rst_req = rst_q;

endmodule

// File: rtl/wdg_guard_chk.sv
// Module: wdg_guard_chk
// Port-level checker for wdg_guard, attached by bind.
// Assumes: expiries are at least two clocks apart (timeout of eight ticks or more).
module wdg_guard_chk #(
    parameter int CEN_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       irq,
    input logic       rst_req,
    input logic [7:0] ctrl_rd
);

    logic       armed;
    logic [7:0] win_age;

    // Enable $past-based checks one cycle after reset ends
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Count how many consecutive cycles the window bit has read one
    always_ff @(posedge clk) begin
        if (!rst_n)                          win_age <= '0;
        else if (ctrl_rd[2] && win_age != 8'hFF) win_age <= win_age + 8'd1;
        else if (!ctrl_rd[2])                win_age <= '0;
    end

    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ctrl_rd[2] |-> (win_age < 8'(CEN_CYCLES))); // R4
    AST_PSEL_GUARD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$stable(ctrl_rd[7:4]) |-> ($past(ctrl_rd[2]) && $past(wr_en))); // R6
    AST_REN_CLEAR_GUARD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $fell(ctrl_rd[0]) |-> ($past(ctrl_rd[2]) && $past(wr_en) && !$past(ctrl_rd[3]))); // R7
    AST_FLAG_PINS_REN: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ctrl_rd[3] |-> ctrl_rd[0]); // R7
    AST_RST_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        rst_req |-> ctrl_rd[3]); // R3
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        rst_req |=> !rst_req); // R3
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        irq |=> !irq); // R2
    AST_IRQ_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        irq |-> $past(ctrl_rd[1])); // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (irq || rst_req) |-> ($past(ctrl_rd[0]) || $past(ctrl_rd[1]))); // R9

endmodule

bind wdg_guard wdg_guard_chk #(.CEN_CYCLES(CEN_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .irq     (irq),
    .rst_req (rst_req),
    .ctrl_rd (ctrl_rd)
);

// File: tb/tb_wdg_guard.sv
// Bench for wdg_guard: directed corner cases then seeded random traffic,
// compared every cycle against a reference model built from the requirements.
module tb_wdg_guard;

    localparam int B = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       kick = 1'b0;
    logic       rst_req, irq;
    logic [7:0] ctrl_rd;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wdg_guard #(.BASE_LOG2(B), .CEN_CYCLES(4)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .kick(kick), .rst_req(rst_req), .irq(irq), .ctrl_rd(ctrl_rd)
    );

    // Reference model state
    bit       m_ren, m_ien, m_cen, m_rfl, m_irq, m_rst;
    bit [3:0] m_psel;
    int       m_age;
    longint   m_cnt;

    function automatic logic [7:0] m_ctrl();
        return {m_psel, m_rfl, m_cen, m_ien, m_ren};
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ren = 0; m_ien = 0; m_cen = 0; m_rfl = 0; m_irq = 0; m_rst = 0;
        m_psel = 0; m_age = 0; m_cnt = 0;
    endtask

    // One clock: drive inputs, advance the model, compare after the edge
    task automatic step(bit w, bit [7:0] d, bit k, bit t);
        bit run, n_ren, n_ien, n_cen, n_rfl, restart, expire;
        bit [3:0] n_psel;
        int n_age;
        longint last, n_cnt;
        wr_en = w; wr_data = d; kick = k; tick = t;
        run = m_ren | m_ien;
        last = (longint'(1) << (B + m_psel)) - 1;
        n_ren = m_ren; n_ien = m_ien; n_psel = m_psel; n_cen = m_cen;
        n_age = m_age; n_rfl = m_rfl;
        if (m_cen) begin
            if (m_age == 3) n_cen = 0;
            else n_age = m_age + 1;
        end
        if (w) begin
            if (m_cen) begin
                n_ren = m_rfl | d[0]; n_ien = d[1]; n_psel = d[7:4]; n_cen = 0;
            end else if (d[2] && d[0]) begin
                n_cen = 1; n_age = 0;
            end else begin
                n_ren = m_ren | d[0]; n_ien = d[1];
            end
            n_rfl = m_rfl & d[3];
        end
        restart = (k && m_ren) || ((n_ren | n_ien) != run) || (n_psel != m_psel);
        expire = run && t && (m_cnt == last) && !restart;
        if (restart || !run || expire) n_cnt = 0;
        else if (t) n_cnt = m_cnt + 1;
        else n_cnt = m_cnt;
        m_irq = expire && m_ien;
        m_rst = expire && m_ren;
        if (m_rst) begin n_rfl = 1; n_ren = 1; end
        @(posedge clk);
        #1;
        m_ren = n_ren; m_ien = n_ien; m_psel = n_psel; m_cen = n_cen;
        m_age = n_age; m_rfl = n_rfl; m_cnt = n_cnt;
        chk("R2 irq", int'(irq), int'(m_irq));
        chk("R3 rst_req", int'(rst_req), int'(m_rst));
        chk("R4/R5/R6/R7/R8 ctrl_rd", int'(ctrl_rd), int'(m_ctrl()));
        @(negedge clk);
        wr_en = 0; kick = 0;
    endtask

    task automatic idle(int n, output int ni, output int nr);
        ni = 0; nr = 0;
        repeat (n) begin
            step(0, 8'h00, 0, 1);
            ni += int'(irq);
            nr += int'(rst_req);
        end
    endtask

    task automatic first_irq(int maxn, output int at);
        at = -1;
        for (int i = 1; i <= maxn; i++) begin
            step(0, 8'h00, 0, 1);
            if (irq === 1'b1 && at < 0) at = i;
        end
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0; kick = 0; tick = 0; wr_data = 0;
        repeat (2) @(posedge clk);
        #1;
        model_reset();
        @(negedge clk);
        rst_n = 1;
    endtask

    // Watchdog for a hung run
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ni, nr, at;
        void'($urandom(32'd20240607));
        do_reset();
        chk("R1 ctrl_rd after reset", int'(ctrl_rd), 0);
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 rst_req after reset", int'(rst_req), 0);

        // R2: irq only, P=0 -> timeout of 8 ticks
        step(1, 8'h02, 0, 1);
        first_irq(8, at);
        chk("R2 timeout length", at, 8);

        // R5: prescaler ignored outside the window
        step(1, 8'h12, 0, 1);
        chk("R5 psel locked", int'(ctrl_rd), 8'h02);

        // R4: unlock sets only the window bit, window lasts 4 clocks
        step(1, 8'h05, 0, 1);
        chk("R4 unlock value", int'(ctrl_rd), 8'h06);
        for (int i = 0; i < 3; i++) begin
            step(0, 8'h00, 0, 1);
            chk("R4 window held", int'(ctrl_rd[2]), 1);
        end
        step(0, 8'h00, 0, 1);
        chk("R4 window closed", int'(ctrl_rd[2]), 0);

        // R6: window write loads guarded fields
        step(1, 8'h05, 0, 1);
        step(1, 8'h23, 0, 1);
        chk("R6 window write", int'(ctrl_rd), 8'h23);

        // R10: kicks keep the 32-tick timeout from expiring
        ni = 0; nr = 0;
        repeat (5) begin
            int a, b;
            idle(20, a, b);
            ni += a; nr += b;
            step(0, 8'h00, 1, 1);
            ni += int'(irq); nr += int'(rst_req);
        end
        chk("R10 kick irq count", ni, 0);
        chk("R10 kick rst count", nr, 0);

        // R3: expiry with reset enable
        idle(40, ni, nr);
        chk("R3 rst pulses", nr, 1);
        chk("R2 irq pulses", ni, 1);
        chk("R3 flag set", int'(ctrl_rd), 8'h2B);

        // R8: writing one to the flag keeps it
        step(1, 8'h0B, 0, 1);
        chk("R8 flag kept", int'(ctrl_rd), 8'h2B);

        // R7: flag pins reset enable inside the window; R8 flag cleared by zero
        step(1, 8'h0D, 0, 1);
        step(1, 8'h20, 0, 1);
        chk("R7 ren pinned", int'(ctrl_rd[0]), 1);
        chk("R8 flag cleared", int'(ctrl_rd[3]), 0);

        // R9: disable, stay silent, then restart from zero
        step(1, 8'h05, 0, 1);
        step(1, 8'h00, 0, 1);
        chk("R9 disabled", int'(ctrl_rd), 8'h00);
        idle(200, ni, nr);
        chk("R9 silent irq", ni, 0);
        chk("R9 silent rst", nr, 0);
        step(1, 8'h02, 0, 1);
        first_irq(8, at);
        chk("R9 restart from zero", at, 8);

        // R5: reset enable set but not cleared outside the window
        step(1, 8'h03, 0, 1);
        chk("R5 ren set", int'(ctrl_rd), 8'h03);
        step(1, 8'h02, 0, 1);
        chk("R5 ren not cleared", int'(ctrl_rd), 8'h03);

        // R11: restart on the final tick suppresses the expiry
        step(0, 8'h00, 1, 1);
        idle(7, ni, nr);
        step(0, 8'h00, 1, 1);
        chk("R11 suppressed irq", int'(irq), 0);
        chk("R11 suppressed rst", int'(rst_req), 0);
        idle(7, ni, nr);
        chk("R11 quiet after restart", ni + nr, 0);
        step(0, 8'h00, 0, 1);
        chk("R11 full timeout later", int'(irq), 1);

        // Random traffic checked every cycle against the model
        do_reset();
        chk("R1 ctrl_rd after second reset", int'(ctrl_rd), 0);
        for (int i = 0; i < 20000; i++) begin
            bit w, k, t;
            bit [7:0] d;
            t = ($urandom % 2) == 0;
            k = ($urandom % 16) == 0;
            w = ($urandom % 8) == 0;
            if (($urandom % 4) == 0) d = {4'($urandom % 3), 1'($urandom), 3'b101};
            else d = {4'($urandom % 3), 4'($urandom)};
            step(w, d, k, t);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule